// File: doc/BRIEF.md
# Sampled Input Glitch Filter

This block removes short glitches from one already-synchronized timer input before that input reaches edge detection. It samples the input at a chosen rate and moves its output to a new level only after a set number of samples in a row all show that new level. A single sample that shows the present output level again throws away the run that was under way.

A 4-bit filter code sets the sampling rate and the run length together, from a fixed table. Three codes sample on every system clock. All other codes sample on a divided copy of an external base-rate enable, at a ratio of 1, 2, 4, 8, 16 or 32. Code 0 gives an unfiltered path: every base-rate sample is copied straight to the output. A change of the code clears the rate divider and the run count. The output keeps its level through a code change.

Top module: `sampled_glitch_filter`

## Requirements
- R1: A synchronous active-low reset drives `filt_out` to 0. It also clears the run count and the rate divider.
- R2: Code 0 has no filtering. Each `base_tick` cycle is a sample, and that sample's `raw_in` value appears on `filt_out` after that clock edge.
- R3: Codes 1, 2 and 3 take a sample on every clock cycle, whatever the state of `base_tick`. They need 2, 4 and 8 agreeing samples respectively.
- R4: Codes 4 and 5 sample on every 2nd `base_tick`, and codes 6 and 7 on every 4th. Within each pair the lower code needs 6 agreeing samples and the higher code needs 8.
- R5: Codes 8 and 9 sample on every 8th `base_tick`. Code 8 needs 6 agreeing samples and code 9 needs 8.
- R6: Codes 10, 11 and 12 sample on every 16th `base_tick`, and codes 13, 14 and 15 on every 32nd. Within each group of three the codes need 5, 6 and 8 agreeing samples, in rising code order.
- R7: `filt_out` changes only on a clock edge that takes a sample. In the divided modes it holds its level while `base_tick` stays low, for as long as that lasts.
- R8: A sample equal to the present `filt_out` level resets the run count to zero. A pulse one sample shorter than the required count therefore never reaches the output.
- R9: In the first clock cycle that the code differs from its registered copy, the block takes no sample, and the run count and the rate divider clear. Counting then starts again under the new code, from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the clock used by the fast codes |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle enable that sets the base sampling rate |
| raw_in | input | 1 | Synchronized raw input level |
| filt_code | input | 4 | Filter code: sampling rate and required sample count |
| filt_out | output | 1 | Filtered level |

## Verification
The only output is a single level, so an internal fault shows up as a change in the output's timing. A wrong divider phase or a wrong entry in the code table moves the output edge by a whole number of sample periods. In the worst case, code 15, that is a 32-clock step, and it is visible within at most 256 base ticks. A run count that is not cleared lets a glitch through, or makes the output switch too early after a code change. Because of this, every code is driven in both directions and the exact switching edge is checked, along with the cycle just before it.

// File: rtl/filt_pkg.sv
// Package: shared sizes and the decoded-configuration type of the glitch filter.
// Assumes: at most a divide-by-32 sampling ratio and at most 8 required samples.
package filt_pkg;
    localparam int CODE_W       = 4;
    localparam int DIV_LOG2_MAX = 5;
    localparam int LOG_W        = $clog2(DIV_LOG2_MAX + 1);
    localparam int CNT_W        = 4;

    typedef struct packed {
        logic             fast;      // sample on every clock
        logic [LOG_W-1:0] div_log2;  // base-rate divide ratio, as a power of two
        logic [CNT_W-1:0] n_req;     // agreeing samples needed to switch
    } filt_cfg_t;
endpackage

// File: rtl/filt_code_decode.sv
// Module: turns the 4-bit filter code into rate and count settings.
// Assumes: code 0 means an unfiltered path, which is a base-rate sample with a count of one.
module filt_code_decode
    import filt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output filt_cfg_t         cfg
);
    // Fixed, irregular lookup from code to divider and count.
    always_comb begin
        cfg = '{fast: 1'b0, div_log2: '0, n_req: CNT_W'(1)};
        unique case (code)
            4'd0:  cfg = '{fast: 1'b0, div_log2: LOG_W'(0), n_req: CNT_W'(1)};
            4'd1:  cfg = '{fast: 1'b1, div_log2: LOG_W'(0), n_req: CNT_W'(2)};
            4'd2:  cfg = '{fast: 1'b1, div_log2: LOG_W'(0), n_req: CNT_W'(4)};
            4'd3:  cfg = '{fast: 1'b1, div_log2: LOG_W'(0), n_req: CNT_W'(8)};
            4'd4:  cfg = '{fast: 1'b0, div_log2: LOG_W'(1), n_req: CNT_W'(6)};
            4'd5:  cfg = '{fast: 1'b0, div_log2: LOG_W'(1), n_req: CNT_W'(8)};
            4'd6:  cfg = '{fast: 1'b0, div_log2: LOG_W'(2), n_req: CNT_W'(6)};
            4'd7:  cfg = '{fast: 1'b0, div_log2: LOG_W'(2), n_req: CNT_W'(8)};
            4'd8:  cfg = '{fast: 1'b0, div_log2: LOG_W'(3), n_req: CNT_W'(6)};
            4'd9:  cfg = '{fast: 1'b0, div_log2: LOG_W'(3), n_req: CNT_W'(8)};
            4'd10: cfg = '{fast: 1'b0, div_log2: LOG_W'(4), n_req: CNT_W'(5)};
            4'd11: cfg = '{fast: 1'b0, div_log2: LOG_W'(4), n_req: CNT_W'(6)};
            4'd12: cfg = '{fast: 1'b0, div_log2: LOG_W'(4), n_req: CNT_W'(8)};
            4'd13: cfg = '{fast: 1'b0, div_log2: LOG_W'(5), n_req: CNT_W'(5)};
            4'd14: cfg = '{fast: 1'b0, div_log2: LOG_W'(5), n_req: CNT_W'(6)};
            4'd15: cfg = '{fast: 1'b0, div_log2: LOG_W'(5), n_req: CNT_W'(8)};
            default: ;
        endcase
    end

    // Every code gives a count between 1 and 8.
    always_comb begin
        AST_COUNT_LEGAL: assert (cfg.n_req >= CNT_W'(1) && cfg.n_req <= CNT_W'(8)) // R6
            else $error("decoded sample count out of range");
    end
endmodule

// File: rtl/filt_prescaler.sv
// Module: divides the base-rate enable into sample strobes, or strobes on every clock in fast mode.
// Assumes: clr is one cycle long at a code change; no strobe is issued in that cycle.
module filt_prescaler
    import filt_pkg::*;
#(
    parameter int DIV_MAX_LOG2 = DIV_LOG2_MAX,
    localparam int DW          = (DIV_MAX_LOG2 < 1) ? 1 : DIV_MAX_LOG2,
    localparam int LW          = $clog2(DIV_MAX_LOG2 + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          base_tick,
    input  logic          fast,
    input  logic [LW-1:0] div_log2,
    output logic          smp_en
);
    logic [DW-1:0] div_cnt;
    logic [DW-1:0] div_last;
    logic          wrap;

    // Last divider count value for the selected ratio.
    always_comb div_last = DW'((32'd1 << div_log2) - 32'd1);

    assign wrap   = base_tick && (div_cnt == div_last);
    assign smp_en = !clr && (fast || wrap);

    // Counts base ticks and wraps at the selected ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_cnt <= '0;
        end else if (!fast && base_tick) begin
            div_cnt <= wrap ? '0 : div_cnt + 1'b1;
        end
    end

    AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> div_cnt == '0)                                   // R9
        else $error("divider not cleared after code change");
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> div_cnt <= div_last)                            // R4
        else $error("divider count past selected ratio");
    AST_FAST_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && !clr) |-> smp_en)                               // R3
        else $error("fast mode missed a sample");
    AST_NO_TICK_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && !base_tick) |-> !smp_en)                       // R7
        else $error("sample strobe without base tick");
endmodule

// File: rtl/filt_match.sv
// Module: counts consecutive samples that differ from the output and switches the output at the required count.
// Assumes: n_req is at least 1; clr only clears the count and keeps the output level.
module filt_match
    import filt_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          smp_en,
    input  logic          din,
    input  logic [CW-1:0] n_req,
    output logic          dout
);
    logic [CW-1:0] run_cnt;
    logic [CW:0]   run_nxt;

    assign run_nxt = {1'b0, run_cnt} + 1'b1;

    // Advances the run on a differing sample and switches the output when the run is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            dout    <= 1'b0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (smp_en) begin
            if (din == dout) begin
                run_cnt <= '0;
            end else if (run_nxt >= {1'b0, n_req}) begin
                dout    <= din;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_nxt[CW-1:0];
            end
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !dout)                                        // R1
        else $error("output not low after reset");
    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(dout))                               // R7
        else $error("output moved without a sample");
    AST_AGREE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && din == dout) |=> run_cnt == '0)               // R8
        else $error("agreeing sample did not restart the run");
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> run_cnt < n_req)                                // R8
        else $error("run count reached the required count");
    AST_CLEAR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (run_cnt == '0 && $stable(dout)))                // R9
        else $error("code change did not clear the run");
endmodule

// File: rtl/sampled_glitch_filter.sv
// Module: top of the sampled glitch filter; decodes the code, detects code changes and joins divider and run counter.
// Assumes: raw_in is already synchronous to clk; base_tick is a one-cycle enable.
module sampled_glitch_filter
    import filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              raw_in,
    input  logic [CODE_W-1:0] filt_code,
    output logic              filt_out
);
    filt_cfg_t         cfg;
    logic [CODE_W-1:0] code_q;
    logic              code_chg;
    logic              smp_en;

    // Keeps the code last seen, so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= filt_code;
    end

    assign code_chg = (filt_code != code_q);

    filt_code_decode u_decode (
        .code (filt_code),
        .cfg  (cfg)
    );

    filt_prescaler #(.DIV_MAX_LOG2(DIV_LOG2_MAX)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (code_chg),
        .base_tick (base_tick),
        .fast      (cfg.fast),
        .div_log2  (cfg.div_log2),
        .smp_en    (smp_en)
    );

    filt_match #(.CW(CNT_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (code_chg),
        .smp_en (smp_en),
        .din    (raw_in),
        .n_req  (cfg.n_req),
        .dout   (filt_out)
    );

    AST_CHANGE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg |=> $stable(filt_out))                          // R9
        else $error("output moved in a code-change cycle");
endmodule

// File: tb/sampled_glitch_filter_bench.sv
module sampled_glitch_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b1;
    logic       raw_in = 1'b0;
    logic [3:0] filt_code = 4'd0;
    logic       filt_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_lvl = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    sampled_glitch_filter u_sampled_glitch_filter (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .raw_in(raw_in), .filt_code(filt_code), .filt_out(filt_out)
    );

    // Expected ratio (clock cycles per sample when base_tick is always high).
    function automatic int exp_div(input int c);
        if (c <= 3) return 1;
        if (c <= 5) return 2;
        if (c <= 7) return 4;
        if (c <= 9) return 8;
        if (c <= 12) return 16;
        return 32;
    endfunction

    function automatic int exp_n(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 8;
            4, 6, 8: return 6;  5, 7, 9: return 8;
            10, 13: return 5;  11, 14: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic string req_of(input int c);
        if (c == 0) return "R2";
        if (c <= 3) return "R3";
        if (c <= 7) return "R4";
        if (c <= 9) return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clears the run count with a different code while the input matches the output.
    task automatic park(input int code);
        filt_code = 4'((code + 1) % 16);
        raw_in = exp_lvl;
        step(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; raw_in = 1'b1; filt_code = 4'd1;
        step(4);
        check("R1", "output in reset", filt_out, 1'b0);
        rst_n = 1'b1; raw_in = 1'b0;
        step(3);
        check("R1", "output after release", filt_out, 1'b0);
        exp_lvl = 1'b0;
    endtask

    // The output switches on edge 1 + ratio*count after the code is set (edge 1 is the clear).
    task automatic t_code(input int code);
        int d = exp_div(code);
        int n = exp_n(code);
        bit nl = !exp_lvl;
        park(code);
        filt_code = 4'(code);
        raw_in = nl;
        step(d * n);
        check(req_of(code), $sformatf("code %0d before switch", code), filt_out, exp_lvl);
        step(1);
        check(req_of(code), $sformatf("code %0d at switch", code), filt_out, nl);
        exp_lvl = nl;
    endtask

    task automatic t_no_tick();
        park(4);
        filt_code = 4'd4; base_tick = 1'b0; raw_in = !exp_lvl;
        step(100);
        check("R7", "divided mode holds without base tick", filt_out, exp_lvl);
        base_tick = 1'b1;
        step(11);
        check("R7", "no switch before 12 ticks", filt_out, exp_lvl);
        step(1);
        check("R7", "switch on 12th tick", filt_out, !exp_lvl);
        exp_lvl = !exp_lvl;
    endtask

    task automatic t_fast_no_tick();
        park(1);
        filt_code = 4'd1; base_tick = 1'b0; raw_in = !exp_lvl;
        step(2);
        check("R3", "fast mode before switch, no tick", filt_out, exp_lvl);
        step(1);
        check("R3", "fast mode switches without tick", filt_out, !exp_lvl);
        exp_lvl = !exp_lvl;
        base_tick = 1'b1;
    endtask

    task automatic t_glitch();
        bit old = exp_lvl;
        park(2);
        filt_code = 4'd2; raw_in = !old;
        step(4);
        raw_in = old;
        step(1);
        raw_in = !old;
        step(3);
        check("R8", "interrupted run does not switch", filt_out, old);
        step(1);
        check("R8", "full run after restart switches", filt_out, !old);
        exp_lvl = !old;
        park(2);
        filt_code = 4'd2; raw_in = old;
        step(4);
        raw_in = !old;
        step(6);
        check("R8", "pulse of 3 samples rejected", filt_out, !old);
    endtask

    task automatic t_code_change();
        bit old = exp_lvl;
        park(2);
        filt_code = 4'd2; raw_in = !old;
        step(4);
        filt_code = 4'd3;
        step(8);
        check("R9", "count restarted at code change", filt_out, old);
        step(1);
        check("R9", "switch after full new count", filt_out, !old);
        exp_lvl = !old;
    endtask

    task automatic t_reset_mid();
        park(1);
        filt_code = 4'd1; raw_in = 1'b1;
        step(6);
        check("R1", "output high before reset", filt_out, 1'b1);
        rst_n = 1'b0;
        step(1);
        check("R1", "reset forces output low", filt_out, 1'b0);
        rst_n = 1'b1; raw_in = 1'b0;
        step(2);
        exp_lvl = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(1);
        t_reset();
        for (int c = 0; c < 16; c++) t_code(c);
        for (int c = 0; c < 16; c++) t_code(c);
        t_no_tick();
        t_fast_no_tick();
        t_glitch();
        t_code_change();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule